// File: doc/BRIEF.md
# Bus Retry Expiration Counter

This block sits beside the request logic of a bus bridge. For every request that the bridge forwards onto its downstream bus, it counts the retry terminations the target gives back. When the count reaches a limit that software has chosen, the block pulses an expiry output so that the request logic drops the transaction. A target that never accepts the request therefore cannot hold the bridge forever. With the same timing, it can also raise an error request toward the upstream bus, but only while error reporting is enabled.

Software selects the limit through a 32-bit control register. Four bits of the register each choose one retry limit. If several of these bits are set, the smallest selected limit applies. A register value of zero turns expiry off. All other bits of the register are fixed at zero. The request logic clears the count at the start of each new request and again when a request completes successfully.

Top module: `retry_expiry_top`

## Requirements
- R1: After reset the control register reads 0x00000000, and `expire_pulse` and `err_req` are low.
- R2: Only bits 8, 16, 24 and 31 of the control register are writable. Every other bit reads as zero whatever is written, so writing 0xFFFFFFFF reads back as 0x81010100.
- R3: The limit bits select these retry counts: bit 8 gives 256, bit 16 gives 65,536, bit 24 gives 16,777,216 and bit 31 gives 2,147,483,648. `expire_pulse` goes high in the cycle after the clock edge that samples the retry which makes the count equal to the limit, and never earlier.
- R4: If several limit bits are set, the smallest selected limit applies.
- R5: While the control register is zero, retries are not counted and `expire_pulse` never asserts.
- R6: `expire_pulse` is high for exactly one cycle. Further retries for the same request produce no second expiry until the count is cleared.
- R7: A high `req_start` or `req_done` clears the count and re-arms expiry. The clear takes priority over a retry that arrives in the same cycle.
- R8: `err_req` asserts together with `expire_pulse` only if `err_report_en` was high at the expiring retry. Otherwise `err_req` stays low.
- R9: A new limit written while a request is pending applies from the next retry. If the count already equals or exceeds the new limit, the next retry causes expiry.
- R10: The retry count is 32 bits wide and never exceeds the largest limit, 2^31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 32 | Write data for the control register |
| cfg_rdata | output | 32 | Current control register value |
| req_start | input | 1 | A new request starts; clears the count |
| req_done | input | 1 | The current request completed; clears the count |
| retry_pulse | input | 1 | One retry termination received downstream |
| err_report_en | input | 1 | Enables error requests toward the upstream bus |
| expire_pulse | output | 1 | One-cycle pulse: discard the pending request |
| err_req | output | 1 | One-cycle upstream error request on expiry |

## Verification
Some properties are checked on every cycle:
- reserved register bits stay zero;
- an expiry pulse never lasts longer than one cycle;
- an expiry never follows a clear or a cycle with no retry;
- an expiry never happens while counting is disabled;
- the error request never appears without an expiry;
- the count stays bounded.

Other behaviour needs the bench's scenarios:
- the exact retry on which expiry occurs at the 256 and 65,536 limits;
- the smallest limit winning when several bits are set;
- the effect of lowering the limit mid-request;
- that only one expiry occurs per request.

// File: rtl/rex_pkg.sv
package rex_pkg;

    localparam int CTRL_W = 32;
    localparam int CNT_W  = 32;
    localparam int N_LIM  = 4;

    typedef logic [CTRL_W-1:0] ctrl_t;
    typedef logic [CNT_W-1:0]  count_t;

    // Register bit that selects limit i; limits rise with i.
    function automatic int lim_bit(input int i);
        case (i)
            0:       return 8;
            1:       return 16;
            2:       return 24;
            default: return 31;
        endcase
    endfunction

    function automatic ctrl_t writable_mask();
        ctrl_t m = '0;
        for (int i = 0; i < N_LIM; i++) m[lim_bit(i)] = 1'b1;
        return m;
    endfunction

    localparam ctrl_t CTRL_MASK = writable_mask();

    typedef struct packed {
        logic   enable;
        count_t value;
    } limit_t;

    typedef struct packed {
        logic fire;
        logic err;
    } expiry_t;

endpackage

// File: rtl/rex_ctrl_reg.sv
module rex_ctrl_reg
    import rex_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  ctrl_t wdata,
    output ctrl_t q
);
    ctrl_t q_r;

    always_ff @(posedge clk) begin
        if (rst)     q_r <= '0;
        else if (wr) q_r <= wdata & CTRL_MASK;
    end

    assign q = q_r;
endmodule

// File: rtl/rex_limit_sel.sv
module rex_limit_sel
    import rex_pkg::*;
(
    input  ctrl_t  ctrl,
    output limit_t limit
);
    logic [N_LIM-1:0] hit;

    for (genvar i = 0; i < N_LIM; i++) begin : g_hit
        assign hit[i] = ctrl[lim_bit(i)];
    end

    // Walk from the largest limit down so the smallest selected one wins.
    always_comb begin
        limit = '0;
        for (int i = N_LIM - 1; i >= 0; i--) begin
            if (hit[i]) begin
                limit.enable = 1'b1;
                limit.value  = count_t'(1) << lim_bit(i);
            end
        end
    end
endmodule

// File: rtl/rex_retry_cnt.sv
module rex_retry_cnt
    import rex_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clear,
    input  logic    retry,
    input  logic    err_en,
    input  limit_t  limit,
    output expiry_t expiry,
    output count_t  count
);
    count_t  cnt_q;
    logic    spent_q;
    expiry_t exp_q;
    count_t  cnt_inc;
    logic    advance;
    logic    reach;

    assign advance = retry && limit.enable && !spent_q;
    assign cnt_inc = cnt_q + count_t'(1);
    assign reach   = (cnt_inc >= limit.value);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q   <= '0;
            spent_q <= 1'b0;
            exp_q   <= '0;
        end else begin
            exp_q <= '0;
            if (advance) begin
                cnt_q <= cnt_inc;
                if (reach) begin
                    spent_q    <= 1'b1;
                    exp_q.fire <= 1'b1;
                    exp_q.err  <= err_en;
                end
            end
        end
    end

    assign expiry = exp_q;
    assign count  = cnt_q;
endmodule

// File: rtl/retry_expiry_top.sv
module retry_expiry_top
    import rex_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        req_start,
    input  logic        req_done,
    input  logic        retry_pulse,
    input  logic        err_report_en,
    output logic        expire_pulse,
    output logic        err_req
);
    ctrl_t   ctrl;
    limit_t  limit;
    expiry_t expiry;
    count_t  retry_count;

    rex_ctrl_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .q     (ctrl)
    );

    rex_limit_sel u_sel (
        .ctrl  (ctrl),
        .limit (limit)
    );

    rex_retry_cnt u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clear  (req_start | req_done),
        .retry  (retry_pulse),
        .err_en (err_report_en),
        .limit  (limit),
        .expiry (expiry),
        .count  (retry_count)
    );

    assign cfg_rdata    = ctrl;
    assign expire_pulse = expiry.fire;
    assign err_req      = expiry.err;
endmodule

// File: rtl/rex_checker.sv
module rex_checker
    import rex_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] cfg_rdata,
    input logic        req_start,
    input logic        req_done,
    input logic        retry_pulse,
    input logic        expire_pulse,
    input logic        err_req,
    input logic [31:0] retry_count
);
    p_reset_r1: assert property (@(posedge clk) $past(rst) |-> (cfg_rdata == 32'h0 && !expire_pulse));

    p_reserved_r2: assert property (@(posedge clk) disable iff (rst) (cfg_rdata & ~CTRL_MASK) == 32'h0);

    p_needs_retry_r3: assert property (@(posedge clk) disable iff (rst) !retry_pulse |=> !expire_pulse);

    p_disabled_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata == 32'h0) |=> !expire_pulse);

    p_one_cycle_r6: assert property (@(posedge clk) disable iff (rst) expire_pulse |=> !expire_pulse);

    p_clear_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (req_start || req_done) |=> (!expire_pulse && retry_count == 32'h0));

    p_err_gated_r8: assert property (@(posedge clk) disable iff (rst) err_req |-> expire_pulse);

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst) retry_count <= 32'h8000_0000);
endmodule

bind retry_expiry_top rex_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_rdata    (cfg_rdata),
    .req_start    (req_start),
    .req_done     (req_done),
    .retry_pulse  (retry_pulse),
    .expire_pulse (expire_pulse),
    .err_req      (err_req),
    .retry_count  (retry_count)
);

// File: tb/sim_retry_expiry_top.sv
`timescale 1ns/1ps
module sim_retry_expiry_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_start = 1'b0;
    logic        req_done = 1'b0;
    logic        retry_pulse = 1'b0;
    logic        err_report_en = 1'b0;
    logic        expire_pulse;
    logic        err_req;

    always #2.5 clk = ~clk;

    retry_expiry_top u0 (
        .clk           (clk),
        .rst           (rst),
        .cfg_wr        (cfg_wr),
        .cfg_wdata     (cfg_wdata),
        .cfg_rdata     (cfg_rdata),
        .req_start     (req_start),
        .req_done      (req_done),
        .retry_pulse   (retry_pulse),
        .err_report_en (err_report_en),
        .expire_pulse  (expire_pulse),
        .err_req       (err_req)
    );

    typedef struct {
        bit    fire;
        bit    err;
        string tag;
    } exp_item_t;

    exp_item_t sb[$];
    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;

    // Bench model state
    longint m_lim = 0;
    longint m_cnt = 0;
    bit     m_spent = 0;
    string  cur_tag = "R1";

    function automatic longint lim_of(input logic [31:0] v);
        if (v[8])  return 64'd256;
        if (v[16]) return 64'd65536;
        if (v[24]) return 64'd16777216;
        if (v[31]) return 64'd2147483648;
        return 0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus; pushes the expected outputs after the edge.
    task automatic step(input bit wr, input logic [31:0] wd, input bit st, input bit dn,
                        input bit rt, input bit en);
        exp_item_t it;
        @(negedge clk);
        cfg_wr = wr; cfg_wdata = wd; req_start = st; req_done = dn;
        retry_pulse = rt; err_report_en = en;
        it.fire = 0; it.err = 0; it.tag = cur_tag;
        if (st || dn) begin
            m_cnt = 0; m_spent = 0;
        end else if (rt && m_lim != 0 && !m_spent) begin
            m_cnt++;
            if (m_cnt >= m_lim) begin
                m_spent = 1; it.fire = 1; it.err = en;
            end
        end
        sb.push_back(it);
        if (wr) m_lim = lim_of(wd);
    endtask

    task automatic retries(input int n, input bit en);
        for (int i = 0; i < n; i++) step(0, '0, 0, 0, 1, en);
    endtask

    // Monitor: compare outputs after each edge with the queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_item_t e;
                e = sb.pop_front();
                checks++;
                if (expire_pulse !== e.fire || err_req !== e.err) begin
                    errors++;
                    $display("FAIL %s actual=%b%b expected=%b%b", e.tag,
                             expire_pulse, err_req, e.fire, e.err);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        check("R1", cfg_rdata, 32'h0);
        check("R1", {31'b0, expire_pulse | err_req}, 32'h0);

        // R2: reserved bits ignore writes
        cur_tag = "R2";
        step(1, 32'hFFFF_FFFF, 0, 0, 0, 0);
        @(negedge clk); check("R2", cfg_rdata, 32'h8101_0100);
        step(1, 32'h7EFE_FEFF, 0, 0, 0, 0);
        @(negedge clk); check("R2", cfg_rdata, 32'h0);

        // R5: zero control never expires
        cur_tag = "R5";
        step(0, '0, 1, 0, 0, 1);
        retries(300, 1);

        // R3 / R8 / R6: 256 limit with error reporting on
        cur_tag = "R3";
        step(1, 32'h0000_0100, 0, 0, 0, 1);
        @(negedge clk); check("R3", cfg_rdata, 32'h0000_0100);
        step(0, '0, 1, 0, 0, 1);
        retries(256, 1);
        cur_tag = "R6";
        retries(10, 1);

        // R7: clear mid-request, clear wins over simultaneous retry
        cur_tag = "R7";
        step(0, '0, 0, 1, 0, 1);
        retries(100, 1);
        step(0, '0, 1, 0, 1, 1);
        retries(256, 1);
        retries(3, 1);

        // R8: error reporting disabled
        cur_tag = "R8";
        step(0, '0, 1, 0, 0, 0);
        retries(256, 0);

        // R4: multiple bits, smallest wins
        cur_tag = "R4";
        step(1, 32'h8101_0100, 1, 0, 0, 1);
        retries(256, 1);

        // R9: lower the limit below the current count
        cur_tag = "R9";
        step(1, 32'h0001_0000, 1, 0, 0, 1);
        retries(300, 1);
        step(1, 32'h0000_0100, 0, 0, 0, 1);
        retries(2, 1);

        // R10 / R3: 64K limit
        cur_tag = "R10";
        step(1, 32'h0001_0000, 1, 0, 0, 1);
        retries(65536, 1);
        retries(2, 1);
        step(0, '0, 0, 1, 0, 1);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule